// File: doc/BRIEF.md
# Semaphore-Guarded Shared Mailbox RAM

This block is a 1 KB message store shared by two agents. One agent is an external host on a byte-wide register bus. The other is a local processor on a second, independent bus. Only one agent owns the store at a time. Ownership is held in a 2-bit semaphore that both agents can read and write at the same register offset.

To take the store, an agent writes its request code to the semaphore and then reads the register back. The value it reads names the owner. The host requests with code 01 and is reported as 01. The processor requests with code 11 and is reported as 11. Code 00 means the store is free. The owner gives the store back by writing 00.

An agent that does not own the store cannot use it. Its RAM reads return zero and its RAM writes are dropped. Each agent has its own RAM port. Read data is registered on every port, so it appears one clock after the request.

Top module: `shared_mailbox`

## Requirements
- R1: After reset the semaphore reads 0x00 (free) on both ports and both read-data outputs are 0x00.
- R2: A semaphore read returns the owner code in bits [1:0]; bits [7:2] always read zero, whatever value was written to them.
- R3: A host write whose bits [1:0] are 01, made while the store is free, gives the store to the host. Afterwards the semaphore reads 01.
- R4: A processor write of 11, made while the store is free, gives the store to the processor. Afterwards the semaphore reads 11. A host request made while the processor owns the store is refused, and the semaphore keeps reading 11.
- R5: A processor request made while the host owns the store is refused, and the semaphore keeps reading 01.
- R6: If both agents request in the same cycle while the store is free, the host wins and the semaphore reads 01.
- R7: A write of 00 frees the store only when the writer is the current owner. A write of 00 from the other agent leaves the owner unchanged.
- R8: The owner reaches RAM byte (offset - 0x2400) for byte offsets 0x2400 to 0x27FF. Read data appears one cycle after the read request. A byte written by one owner can be read by the next owner.
- R9: While the host does not own the store, its RAM reads return 0x00 and its RAM writes leave the contents unchanged.
- R10: While the processor does not own the store, its RAM reads return 0x00 and its RAM writes leave the contents unchanged.
- R11: Semaphore writes with any other code leave the state unchanged. This covers code 10 from either agent, code 11 from the host and code 01 from the processor.
- R12: Reads of offsets outside the semaphore (0x001E) and the RAM window return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostEn | input | 1 | Host access request |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | 14 | Host byte offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, one cycle after the request |
| cpuEn | input | 1 | Processor access request |
| cpuWe | input | 1 | Processor write (1) or read (0) |
| cpuAddr | input | 14 | Processor byte offset (same map as the host) |
| cpuWdata | input | 8 | Processor write data |
| cpuRdata | output | 8 | Processor read data, one cycle after the request |

## Verification
A semaphore write changes the owner at the same clock edge that captures it. The ownership check for a RAM access uses the owner as it stood in the request cycle, so a grant takes effect for accesses made from the next cycle on. Read data for the semaphore, the RAM or an unmapped offset is registered at the edge that captures the request. The bench drives each request on a falling edge and samples the read data at the next falling edge, half a cycle after it was registered. The outcome of each semaphore write is checked by a readback in the following cycle, which is the protocol the agents themselves use.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    SEM_FREE = 2'b00,
    SEM_HOST = 2'b01,
    SEM_CPU  = 2'b11
  } semState_t;

  // strobes from control to datapath, one set per agent
  typedef struct packed {
    logic ramRd;
    logic ramWr;
    logic semRd;
  } mboxStb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int RAM_BASE = 'h2400,
  parameter int RAM_SIZE = 1024,
  parameter int SEM_OFFS = 'h001E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostEn,
  input  logic        hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]  hostCode,
  input  logic        cpuEn,
  input  logic        cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]  cpuCode,
  output mboxStb_t    hostStb,
  output mboxStb_t    cpuStb,
  output semState_t   semCode
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W:0]   END_A  = (ADDR_W+1)'(RAM_BASE + RAM_SIZE);
  localparam logic [ADDR_W-1:0] SEM_A  = ADDR_W'(SEM_OFFS);

  semState_t semQ, semD;
  logic hostInRam, cpuInRam, hostAtSem, cpuAtSem;
  logic hostSemWr, cpuSemWr, hostAsk, cpuAsk, hostFree, cpuFree;

  always_comb begin
    hostInRam = (hostAddr >= BASE_A) && ({1'b0, hostAddr} < END_A);
    cpuInRam  = (cpuAddr  >= BASE_A) && ({1'b0, cpuAddr}  < END_A);
    hostAtSem = (hostAddr == SEM_A);
    cpuAtSem  = (cpuAddr  == SEM_A);
    hostSemWr = hostEn && hostWe && hostAtSem;
    cpuSemWr  = cpuEn  && cpuWe  && cpuAtSem;
    hostAsk   = hostSemWr && (hostCode == 2'b01);
    cpuAsk    = cpuSemWr  && (cpuCode  == 2'b11);
    hostFree  = hostSemWr && (hostCode == 2'b00);
    cpuFree   = cpuSemWr  && (cpuCode  == 2'b00);
  end

  // next owner: host wins a tie on a free store
  always_comb begin
    semD = semQ;
    unique case (semQ)
      SEM_FREE: if (hostAsk) semD = SEM_HOST;
                else if (cpuAsk) semD = SEM_CPU;
      SEM_HOST: if (hostFree) semD = SEM_FREE;
      SEM_CPU:  if (cpuFree) semD = SEM_FREE;
      default:  semD = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) semQ <= SEM_FREE;
    else       semQ <= semD;
  end

  // ownership gating uses the owner of the request cycle
  always_comb begin
    hostStb.ramRd = hostEn && !hostWe && hostInRam && (semQ == SEM_HOST);
    hostStb.ramWr = hostEn &&  hostWe && hostInRam && (semQ == SEM_HOST);
    hostStb.semRd = hostEn && !hostWe && hostAtSem;
    cpuStb.ramRd  = cpuEn  && !cpuWe  && cpuInRam  && (semQ == SEM_CPU);
    cpuStb.ramWr  = cpuEn  &&  cpuWe  && cpuInRam  && (semQ == SEM_CPU);
    cpuStb.semRd  = cpuEn  && !cpuWe  && cpuAtSem;
  end

  assign semCode = semQ;

  a_r3_host_grant: assert property (@(posedge clk) disable iff (!rstN)
    (semQ == SEM_FREE && hostAsk) |=> (semQ == SEM_HOST));
  a_r5_cpu_refused: assert property (@(posedge clk) disable iff (!rstN)
    (semQ == SEM_HOST && cpuAsk) |=> (semQ != SEM_CPU));
  a_r4_host_refused: assert property (@(posedge clk) disable iff (!rstN)
    (semQ == SEM_CPU && hostAsk) |=> (semQ == SEM_CPU));
  a_r7_foreign_release: assert property (@(posedge clk) disable iff (!rstN)
    (semQ == SEM_CPU && hostFree && !cpuFree) |=> (semQ == SEM_CPU));
  a_r11_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    semQ != 2'b10);
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RAM_SIZE = 1024,
  localparam int IDX_W   = $clog2(RAM_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStb_t          hostStb,
  input  mboxStb_t          cpuStb,
  input  logic [IDX_W-1:0]  hostIdx,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] cpuWdata,
  input  semState_t         semCode,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] cpuRdata
);
  logic [DATA_W-1:0] mem [RAM_SIZE];
  logic [DATA_W-1:0] semWord;

  assign semWord = {{(DATA_W-2){1'b0}}, semCode};

  // at most one port writes: only the owner gets a write strobe
  always_ff @(posedge clk) begin
    if (hostStb.ramWr) mem[hostIdx] <= hostWdata;
    if (cpuStb.ramWr)  mem[cpuIdx]  <= cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
      cpuRdata  <= '0;
    end else begin
      hostRdata <= hostStb.ramRd ? mem[hostIdx] : (hostStb.semRd ? semWord : '0);
      cpuRdata  <= cpuStb.ramRd  ? mem[cpuIdx]  : (cpuStb.semRd  ? semWord : '0);
    end
  end

  a_r9_host_wr_owned: assert property (@(posedge clk) disable iff (!rstN)
    hostStb.ramWr |-> (semCode == SEM_HOST));
  a_r10_cpu_wr_owned: assert property (@(posedge clk) disable iff (!rstN)
    cpuStb.ramWr |-> (semCode == SEM_CPU));
  a_r8_single_writer: assert property (@(posedge clk) disable iff (!rstN)
    !(hostStb.ramWr && cpuStb.ramWr));
endmodule

// File: rtl/shared_mailbox.sv
module shared_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 'h2400,
  parameter int RAM_SIZE = 1024,
  parameter int SEM_OFFS = 'h001E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              cpuEn,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int IDX_W = $clog2(RAM_SIZE);

  mboxStb_t  hostStb, cpuStb;
  semState_t semCode;

  mbox_ctrl #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
              .SEM_OFFS(SEM_OFFS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr), .hostCode(hostWdata[1:0]),
    .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuCode(cpuWdata[1:0]),
    .hostStb(hostStb), .cpuStb(cpuStb), .semCode(semCode));

  // window base is size-aligned, so the low bits index the RAM
  mbox_dpath #(.DATA_W(DATA_W), .RAM_SIZE(RAM_SIZE)) uDpath (
    .clk(clk), .rstN(rstN),
    .hostStb(hostStb), .cpuStb(cpuStb),
    .hostIdx(hostAddr[IDX_W-1:0]), .cpuIdx(cpuAddr[IDX_W-1:0]),
    .hostWdata(hostWdata), .cpuWdata(cpuWdata), .semCode(semCode),
    .hostRdata(hostRdata), .cpuRdata(cpuRdata));

  a_r9_blocked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && !hostWe && !hostStb.ramRd && !hostStb.semRd) |=> (hostRdata == '0));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && !hostWe && hostStb.semRd) |=> (hostRdata[DATA_W-1:2] == '0));
endmodule

// File: tb/shared_mailbox_test.sv
module shared_mailbox_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic hostEn = 0, hostWe = 0, cpuEn = 0, cpuWe = 0;
  logic [13:0] hostAddr = '0, cpuAddr = '0;
  logic [7:0] hostWdata = '0, cpuWdata = '0;
  logic [7:0] hostRdata, cpuRdata;
  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [7:0] got;

  localparam logic [13:0] SEM = 14'h001E;

  always #10 clk = ~clk;

  shared_mailbox uut (.clk(clk), .rstN(rstN),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one access per call; requests driven on falling edges, data sampled one cycle later
  task automatic hostAcc(input logic we, input logic [13:0] a, input logic [7:0] d,
                         output logic [7:0] r);
    @(negedge clk);
    hostEn = 1; hostWe = we; hostAddr = a; hostWdata = d;
    @(negedge clk);
    r = hostRdata;
    hostEn = 0; hostWe = 0;
  endtask

  task automatic cpuAcc(input logic we, input logic [13:0] a, input logic [7:0] d,
                        output logic [7:0] r);
    @(negedge clk);
    cpuEn = 1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    r = cpuRdata;
    cpuEn = 0; cpuWe = 0;
  endtask

  task automatic testReset;
    @(negedge clk);
    check(hostRdata, 8'h00, "R1 host rdata");
    check(cpuRdata, 8'h00, "R1 cpu rdata");
    hostAcc(0, SEM, 0, got); check(got, 8'h00, "R1 host sem");
    cpuAcc(0, SEM, 0, got);  check(got, 8'h00, "R1 cpu sem");
    hostAcc(1, SEM, 8'h03, got);               // host code 11: ignored
    hostAcc(0, SEM, 0, got); check(got, 8'h00, "R11 host 11");
  endtask

  task automatic testHostOwns;
    hostAcc(1, SEM, 8'hFD, got);               // code 01 with reserved bits set
    hostAcc(0, SEM, 0, got); check(got, 8'h01, "R3/R2 host grant");
    hostAcc(1, 14'h2400, 8'hA5, got);
    hostAcc(1, 14'h27FF, 8'h3C, got);
    hostAcc(1, 14'h2555, 8'h77, got);
    hostAcc(0, 14'h2400, 0, got); check(got, 8'hA5, "R8 low edge");
    hostAcc(0, 14'h27FF, 0, got); check(got, 8'h3C, "R8 high edge");
    hostAcc(0, 14'h2555, 0, got); check(got, 8'h77, "R8 mid");
    cpuAcc(0, 14'h2400, 0, got);  check(got, 8'h00, "R10 cpu blocked read");
    cpuAcc(1, 14'h2400, 8'h5A, got);
    hostAcc(0, 14'h2400, 0, got); check(got, 8'hA5, "R10 cpu blocked write");
    cpuAcc(1, SEM, 8'h03, got);
    cpuAcc(0, SEM, 0, got); check(got, 8'h01, "R5 cpu refused");
    cpuAcc(1, SEM, 8'h00, got);
    cpuAcc(0, SEM, 0, got); check(got, 8'h01, "R7 cpu foreign release");
    hostAcc(0, 14'h2800, 0, got); check(got, 8'h00, "R12 above window");
    hostAcc(0, 14'h23FF, 0, got); check(got, 8'h00, "R12 below window");
    hostAcc(0, 14'h001F, 0, got); check(got, 8'h00, "R12 next to sem");
    hostAcc(1, SEM, 8'h00, got);
    hostAcc(0, SEM, 0, got); check(got, 8'h00, "R7 host release");
  endtask

  task automatic testCpuOwns;
    cpuAcc(1, SEM, 8'h03, got);
    cpuAcc(0, SEM, 0, got); check(got, 8'h03, "R4 cpu grant");
    hostAcc(1, SEM, 8'h01, got);
    hostAcc(0, SEM, 0, got); check(got, 8'h03, "R4 host refused");
    hostAcc(0, 14'h2400, 0, got); check(got, 8'h00, "R9 host blocked read");
    hostAcc(1, 14'h2400, 8'hFF, got);
    cpuAcc(0, 14'h2400, 0, got); check(got, 8'hA5, "R9 host blocked write");
    cpuAcc(1, 14'h2401, 8'hC3, got);
    hostAcc(1, SEM, 8'h00, got);
    hostAcc(0, SEM, 0, got); check(got, 8'h03, "R7 host foreign release");
    cpuAcc(1, SEM, 8'h01, got);
    cpuAcc(0, SEM, 0, got); check(got, 8'h03, "R11 cpu 01");
    cpuAcc(1, SEM, 8'h02, got);
    cpuAcc(0, SEM, 0, got); check(got, 8'h03, "R11 cpu 10");
    cpuAcc(1, SEM, 8'h00, got);
    cpuAcc(0, SEM, 0, got); check(got, 8'h00, "R7 cpu release");
  endtask

  task automatic testTie;
    @(negedge clk);
    hostEn = 1; hostWe = 1; hostAddr = SEM; hostWdata = 8'h01;
    cpuEn  = 1; cpuWe  = 1; cpuAddr  = SEM; cpuWdata  = 8'h03;
    @(negedge clk);
    hostEn = 0; hostWe = 0; cpuEn = 0; cpuWe = 0;
    cpuAcc(0, SEM, 0, got); check(got, 8'h01, "R6 host wins tie");
    hostAcc(0, 14'h2401, 0, got); check(got, 8'hC3, "R8 handover data");
    hostAcc(1, SEM, 8'h02, got);
    hostAcc(0, SEM, 0, got); check(got, 8'h01, "R11 host 10");
    hostAcc(1, SEM, 8'h00, got);
    hostAcc(0, SEM, 0, got); check(got, 8'h00, "R7 release after tie");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHostOwns();
    testCpuOwns();
    testTie();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule